// File: doc/BRIEF.md
# Inter-processor and interval-timer interrupt register

This block keeps one 64-bit control/status word shared by up to four processors, plus one interval-ignore counter per processor. Software reaches the word and the counters through a single 64-bit register port. Each access carries the index of the processor making it, and a read of the control word reports that index in its two lowest bits. The word's bits drive two interrupt lines for each processor: an inter-processor interrupt, and an interval timer interrupt.

Each field of the control word reacts to a write in its own way:

- Some bits clear when a one is written to them.
- Some bits set when a one is written to them.
- One nibble can be set only while it holds zero.
- One data bit acts as a command that wipes an arbitration byte.
- A request nibble raises the matching inter-processor interrupt bits.
- One nibble is plain read/write.

A periodic tick input is edge-detected. On each rising edge, every counter decrements and keeps a sticky overflow flag. While a counter's flag is set, each tick raises that processor's timer interrupt bit. Software can only clear that bit.

Top module: `cpu_event_ctrl`

## Requirements
- R1: After reset the control word holds 0x0000_0008_0000_0000 (revision bit 35 set), every counter reads 0, and `ipi_o` and `iti_o` are 0.
- R2: A read at offset 0x080 returns the stored control word with bits 1:0 replaced by `req_cpu`. Counters 0..3 read at offsets 0x380, 0x3C0, 0x700 and 0x740 as 25-bit values, zero-extended. Any other offset reads 0, and a write to such an offset changes nothing.
- R3: In a control-word write, every bit that is 1 in the data under mask 0x0000_0000_1000_0FF0 clears the stored bit. This covers timer bits 7:4, inter-processor bits 11:8 and bit 28.
- R4: In a control-word write, data bit 12+n sets stored bit 8+n, and this set wins over a clear of the same bit in the same write. `ipi_o[i]` equals stored bit 8+i and changes on the clock edge that takes the write.
- R5: A control-word write with data bit 20 = 1 clears bits 23:16. Without it, ones in data bits 23:21 set the stored bits.
- R6: When data bit 20 = 0, data bits 19:16 are loaded into stored bits 19:16 only while those stored bits are all zero. Otherwise the stored bits are left unchanged.
- R7: Bits 43:40 take the written data. Bit 35 and bits 1:0 cannot be written.
- R8: A write to counter i stores data bits 23:0 and clears overflow bit 24. It does not touch the timer interrupt bits.
- R9: On a rising edge of `tick`, each counter not being written decrements its 25-bit value modulo 2^25, and bit 24 stays set once it is set. A tick held high counts once. A counter write in the same cycle as a tick edge takes the written value.
- R10: When counter i has bit 24 set after a tick update, control bit 4+i (`iti_o[i]`) is set. This set wins over a software clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Byte offset of the 64-bit access |
| reg_wdata | input | 64 | Write data |
| req_cpu | input | 2 | Index of the processor making the access |
| tick | input | 1 | Periodic timer tick, edge-detected |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| ipi_o | output | 4 | Inter-processor interrupt, one per processor |
| iti_o | output | 4 | Interval timer interrupt, one per processor |

## Verification
The hardest situation to reach is a tick edge that lands in the same cycle as a software clear of the timer bit, while that counter is already overflowed. The stimulus first loads a small count and pulses the tick until bit 24 becomes sticky. It then raises the tick in the same cycle as a control-word write that clears the timer bit. Holding the tick high for several cycles, and reloading a counter in the same cycle as a tick edge, cover the remaining orderings. A long randomized phase that favours small counter loads then mixes these events freely against the reference model.

// File: rtl/cpu_evt_pkg.sv
`timescale 1ns/1ps
package cpu_evt_pkg;
    localparam int NCPU   = 4;
    localparam int DATA_W = 64;
    localparam int ADDR_W = 12;
    localparam int ICNT_W = 24;
    localparam int CNT_W  = ICNT_W + 1;

    localparam logic [ADDR_W-1:0] CTRL_OFF   = 12'h080;
    localparam logic [DATA_W-1:0] CLR_ON_ONE = 64'h0000_0000_1000_0FF0;
    localparam logic [DATA_W-1:0] PLAIN_RW   = 64'h0000_0F00_0000_0000;
    localparam logic [DATA_W-1:0] CTRL_RESET = 64'h0000_0008_0000_0000;

    // Bit positions inside the control word
    localparam int TMR_LSB  = 4;
    localparam int IPI_LSB  = 8;
    localparam int REQ_LSB  = 12;
    localparam int COND_LSB = 16;
    localparam int SET_LSB  = 20;
    localparam int WIPE_BIT = 20;

    // Counter offsets: two pairs, 64 bytes apart inside each pair
    function automatic logic [ADDR_W-1:0] ctr_offset(input int idx);
        if (idx < 2) return ADDR_W'(12'h380 + idx * 64);
        else         return ADDR_W'(12'h700 + (idx - 2) * 64);
    endfunction

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic              tick_q;
    } evt_state_t;
endpackage

// File: rtl/evt_ctrl_next.sv
`timescale 1ns/1ps
module evt_ctrl_next
    import cpu_evt_pkg::*;
(
    input  logic [DATA_W-1:0] cur_q,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NCPU-1:0]   timer_set,
    output logic [DATA_W-1:0] nxt_d
);
    always_comb begin
        nxt_d = cur_q;
        if (wr_en) begin
            // clear-on-one fields
            nxt_d = nxt_d & ~(wdata & CLR_ON_ONE);
            if (wdata[WIPE_BIT]) begin
                nxt_d[SET_LSB+3:COND_LSB] = '0;
            end else begin
                nxt_d[SET_LSB+3:SET_LSB] = nxt_d[SET_LSB+3:SET_LSB] | wdata[SET_LSB+3:SET_LSB];
                if (nxt_d[COND_LSB+3:COND_LSB] == 4'h0)
                    nxt_d[COND_LSB+3:COND_LSB] = wdata[COND_LSB+3:COND_LSB];
            end
            // request nibble raises IPI after the clear, so the set wins
            nxt_d[IPI_LSB+NCPU-1:IPI_LSB] = nxt_d[IPI_LSB+NCPU-1:IPI_LSB]
                                          | wdata[REQ_LSB+NCPU-1:REQ_LSB];
            nxt_d = (nxt_d & ~PLAIN_RW) | (wdata & PLAIN_RW);
        end
        // counter overflow sets timer bits last: wins over a software clear
        nxt_d[TMR_LSB+NCPU-1:TMR_LSB] = nxt_d[TMR_LSB+NCPU-1:TMR_LSB] | timer_set;
    end
endmodule

// File: rtl/evt_interval_ctr.sv
`timescale 1ns/1ps
module evt_interval_ctr #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W:0]   cnt_q,
    output logic         timer_set
);
    logic [W:0] cnt_d;
    logic [W:0] dec_val;

    always_comb begin
        dec_val   = cnt_q - (W+1)'(1);
        cnt_d     = cnt_q;
        timer_set = 1'b0;
        if (load) begin
            cnt_d = {1'b0, load_val};
        end else if (dec) begin
            cnt_d     = {cnt_q[W] | dec_val[W], dec_val[W-1:0]};
            timer_set = cnt_d[W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cpu_event_ctrl.sv
`timescale 1ns/1ps
module cpu_event_ctrl
    import cpu_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [1:0]        req_cpu,
    input  logic              tick,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NCPU-1:0]   ipi_o,
    output logic [NCPU-1:0]   iti_o
);
    evt_state_t state_d, state_q;

    logic                  tick_rise;
    logic                  ctrl_wr;
    logic [NCPU-1:0]       ctr_ld;
    logic [NCPU-1:0]       tmr_set;
    logic [CNT_W-1:0]      cnt_q [NCPU];
    logic [NCPU*CNT_W-1:0] cnt_flat;
    logic [DATA_W-1:0]     ctrl_nxt;
    logic [DATA_W-1:0]     ctrl_q;

    assign tick_rise = tick & ~state_q.tick_q;
    assign ctrl_wr   = reg_we && (reg_addr == CTRL_OFF);
    assign ctrl_q    = state_q.ctrl;

    for (genvar i = 0; i < NCPU; i++) begin : g_ctr
        assign ctr_ld[i] = reg_we && (reg_addr == ctr_offset(i));
        evt_interval_ctr #(.W(ICNT_W)) u_ctr (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (ctr_ld[i]),
            .load_val  (reg_wdata[ICNT_W-1:0]),
            .dec       (tick_rise),
            .cnt_q     (cnt_q[i]),
            .timer_set (tmr_set[i])
        );
        assign cnt_flat[i*CNT_W +: CNT_W] = cnt_q[i];
    end

    evt_ctrl_next u_next (
        .cur_q     (state_q.ctrl),
        .wr_en     (ctrl_wr),
        .wdata     (reg_wdata),
        .timer_set (tmr_set),
        .nxt_d     (ctrl_nxt)
    );

    always_comb begin
        state_d        = state_q;
        state_d.ctrl   = ctrl_nxt;
        state_d.tick_q = tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '{ctrl: CTRL_RESET, tick_q: 1'b0};
        else        state_q <= state_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_OFF)
            reg_rdata = state_q.ctrl | {{(DATA_W-2){1'b0}}, req_cpu};
        for (int i = 0; i < NCPU; i++) begin
            if (reg_addr == ctr_offset(i))
                reg_rdata = DATA_W'(cnt_q[i]);
        end
    end

    assign ipi_o = state_q.ctrl[IPI_LSB +: NCPU];
    assign iti_o = state_q.ctrl[TMR_LSB +: NCPU];
endmodule

// File: rtl/evt_ctrl_checker.sv
`timescale 1ns/1ps
module evt_ctrl_checker
    import cpu_evt_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_we,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic [DATA_W-1:0]     reg_wdata,
    input logic                  tick,
    input logic [NCPU-1:0]       ipi_o,
    input logic [NCPU-1:0]       iti_o,
    input logic [DATA_W-1:0]     ctrl_q,
    input logic [NCPU*CNT_W-1:0] cnt_flat
);
    logic wr_ctrl;
    assign wr_ctrl = reg_we && (reg_addr == CTRL_OFF);

    // R4: without a control write the IPI lines hold
    p_ipi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ipi_o));

    // R4: requested IPI bits are up one cycle after the write
    p_ipi_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> ((ipi_o & $past(reg_wdata[REQ_LSB +: NCPU])) == $past(reg_wdata[REQ_LSB +: NCPU])));

    // R3: writing one to bit 28 clears it
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && reg_wdata[28]) |=> !ctrl_q[28]);

    // R10: timer bits never fall without a control write
    p_iti_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> ((iti_o & $past(iti_o)) == $past(iti_o)));

    // R6: a nonzero conditional nibble ignores set attempts
    p_cond_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !reg_wdata[WIPE_BIT] && ctrl_q[COND_LSB +: 4] != 4'h0)
        |=> (ctrl_q[COND_LSB +: 4] == $past(ctrl_q[COND_LSB +: 4])));

    // R9: a tick held high does not count again
    p_tick_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && $past(tick) && $past(rst_n) && !reg_we) |=> $stable(cnt_flat));

    for (genvar i = 0; i < NCPU; i++) begin : g_ovf
        // R9: overflow bit is sticky until the counter is written
        p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_flat[i*CNT_W + ICNT_W] && !(reg_we && reg_addr == ctr_offset(i)))
            |=> cnt_flat[i*CNT_W + ICNT_W]);
    end
endmodule

bind cpu_event_ctrl evt_ctrl_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .tick      (tick),
    .ipi_o     (ipi_o),
    .iti_o     (iti_o),
    .ctrl_q    (ctrl_q),
    .cnt_flat  (cnt_flat)
);

// File: tb/tb_cpu_event_ctrl.sv
`timescale 1ns/1ps
module tb_cpu_event_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = 12'h000;
    logic [63:0] reg_wdata = 64'h0;
    logic [1:0]  req_cpu = 2'd0;
    logic        tick = 1'b0;
    logic [63:0] reg_rdata;
    logic [3:0]  ipi_o;
    logic [3:0]  iti_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cpu_event_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .req_cpu(req_cpu), .tick(tick),
        .reg_rdata(reg_rdata), .ipi_o(ipi_o), .iti_o(iti_o)
    );

    // ---------------- reference model ----------------
    logic [63:0] m_ctrl;
    logic [24:0] m_cnt [4];
    logic        m_tprev;

    function automatic logic [11:0] offs(input int i);
        case (i)
            0: return 12'h380;
            1: return 12'h3C0;
            2: return 12'h700;
            default: return 12'h740;
        endcase
    endfunction

    function automatic logic [63:0] m_read(input logic [11:0] a, input logic [1:0] c);
        if (a == 12'h080) return m_ctrl | {62'd0, c};
        for (int i = 0; i < 4; i++)
            if (a == offs(i)) return {39'd0, m_cnt[i]};
        return 64'd0;
    endfunction

    always @(posedge clk) begin : model
        logic rise;
        if (!rst_n) begin
            m_ctrl  = 64'h0000_0008_0000_0000;
            for (int i = 0; i < 4; i++) m_cnt[i] = 25'd0;
            m_tprev = 1'b0;
        end else begin
            rise    = tick && !m_tprev;
            m_tprev = tick;
            if (reg_we && reg_addr == 12'h080) begin
                m_ctrl = m_ctrl & ~(reg_wdata & 64'h1000_0FF0);
                if (reg_wdata[20]) m_ctrl[23:16] = 8'h00;
                else begin
                    m_ctrl[23:20] = m_ctrl[23:20] | reg_wdata[23:20];
                    if (m_ctrl[19:16] == 4'h0) m_ctrl[19:16] = reg_wdata[19:16];
                end
                m_ctrl[11:8]  = m_ctrl[11:8] | reg_wdata[15:12];
                m_ctrl[43:40] = reg_wdata[43:40];
            end
            for (int i = 0; i < 4; i++) begin
                if (reg_we && reg_addr == offs(i)) m_cnt[i] = {1'b0, reg_wdata[23:0]};
                else if (rise) begin
                    m_cnt[i] = (m_cnt[i] - 25'd1) | (m_cnt[i] & 25'h100_0000);
                    if (m_cnt[i][24]) m_ctrl[4+i] = 1'b1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 ipi_o vs model", {60'd0, ipi_o}, {60'd0, m_ctrl[11:8]});
            chk("R10 iti_o vs model", {60'd0, iti_o}, {60'd0, m_ctrl[7:4]});
            chk("R2 reg_rdata vs model", reg_rdata, m_read(reg_addr, req_cpu));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(posedge clk); #2;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [1:0] c,
                          input logic [63:0] exp, input string tag);
        @(posedge clk); #2;
        reg_we = 1'b0; reg_addr = a; req_cpu = c;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic pulse_tick();
        @(posedge clk); #2; tick = 1'b1;
        @(posedge clk); #2; tick = 1'b0;
    endtask

    task automatic now_chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        #1;
        chk(tag, {60'd0, act}, {60'd0, exp});
    endtask

    initial begin : watchdog
        #(500_000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        rd_chk(12'h080, 2'd2, 64'h0000_0008_0000_0002, "R1 reset ctrl, cpu 2");
        rd_chk(12'h080, 2'd3, 64'h0000_0008_0000_0003, "R2 cpu index in read");
        for (int i = 0; i < 4; i++) rd_chk(offs(i), 2'd0, 64'd0, "R1 reset counter");
        now_chk("R1 reset outputs", ipi_o | iti_o, 4'h0);
        rd_chk(12'h100, 2'd1, 64'd0, "R2 unmapped reads zero");
        wr(12'h100, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_chk(12'h080, 2'd0, 64'h0000_0008_0000_0000, "R2 unmapped write ignored (ctrl)");
        rd_chk(12'h380, 2'd0, 64'd0, "R2 unmapped write ignored (counter)");

        wr(12'h080, 64'h0000_0000_0000_F000);
        now_chk("R4 request sets all IPI", ipi_o, 4'hF);
        wr(12'h080, 64'h0000_0000_0000_0100);
        now_chk("R3 clear IPI bit 8", ipi_o, 4'hE);
        wr(12'h080, 64'h0000_0000_0000_1100);
        now_chk("R4 set wins over clear", ipi_o, 4'hF);

        wr(12'h080, 64'h0000_0000_00E0_0000);
        rd_chk(12'h080, 2'd0, 64'h0000_0008_00E0_0F00, "R5 set bits 23:21");
        wr(12'h080, 64'h0000_0000_0003_0000);
        rd_chk(12'h080, 2'd0, 64'h0000_0008_00E3_0F00, "R6 load nibble when zero");
        wr(12'h080, 64'h0000_0000_000C_0000);
        rd_chk(12'h080, 2'd0, 64'h0000_0008_00E3_0F00, "R6 nibble nonzero, no load");
        wr(12'h080, 64'h0000_0000_0010_0000);
        rd_chk(12'h080, 2'd0, 64'h0000_0008_0000_0F00, "R5 wipe command");
        wr(12'h080, 64'h0000_0000_000C_0000);
        rd_chk(12'h080, 2'd0, 64'h0000_0008_000C_0F00, "R6 load after wipe");

        wr(12'h080, 64'h0000_0A00_0000_0F00);
        rd_chk(12'h080, 2'd1, 64'h0000_0A08_000C_0001, "R7 plain field written, bit 35 kept");
        wr(12'h080, 64'h0000_0500_0000_0003);
        rd_chk(12'h080, 2'd0, 64'h0000_0508_000C_0000, "R7 bits 1:0 not stored");

        wr(12'h380, 64'd1000);
        wr(12'h700, 64'd1000);
        wr(12'h740, 64'd1000);
        wr(12'h3C0, 64'h0000_ABCD_1200_0003);
        rd_chk(12'h3C0, 2'd0, 64'h3, "R8 counter keeps low 24 bits");
        repeat (3) pulse_tick();
        rd_chk(12'h3C0, 2'd0, 64'h0, "R9 three ticks");
        now_chk("R10 no timer before overflow", iti_o, 4'h0);
        pulse_tick();
        rd_chk(12'h3C0, 2'd0, 64'h1FF_FFFF, "R9 wrap into overflow");
        now_chk("R10 timer bit for counter 1", iti_o, 4'b0010);

        @(posedge clk); #2 tick = 1'b1;
        repeat (5) @(posedge clk);
        #2 tick = 1'b0;
        rd_chk(12'h3C0, 2'd0, 64'h1FF_FFFE, "R9 held tick counts once");

        wr(12'h080, 64'h0000_0000_0000_0020);
        now_chk("R3 software clears timer bit", iti_o, 4'h0);
        pulse_tick();
        now_chk("R10 next tick sets timer bit again", iti_o, 4'b0010);

        @(posedge clk); #2;
        reg_we = 1'b1; reg_addr = 12'h080; reg_wdata = 64'h20; tick = 1'b1;
        @(posedge clk); #2;
        reg_we = 1'b0; tick = 1'b0;
        now_chk("R10 tick set wins over clear", iti_o, 4'b0010);
        rd_chk(12'h3C0, 2'd0, 64'h1FF_FFFC, "R9 sticky overflow bit");

        wr(12'h3C0, 64'h10);
        rd_chk(12'h3C0, 2'd0, 64'h10, "R8 write clears overflow");
        now_chk("R8 counter write leaves timer bit", iti_o, 4'b0010);

        @(posedge clk); #2;
        reg_we = 1'b1; reg_addr = 12'h380; reg_wdata = 64'd5; tick = 1'b1;
        @(posedge clk); #2;
        reg_we = 1'b0; tick = 1'b0;
        rd_chk(12'h380, 2'd0, 64'd5, "R9 write beats tick");

        wr(12'h740, 64'd0);
        pulse_tick();
        rd_chk(12'h740, 2'd0, 64'h1FF_FFFF, "R9 zero wraps to all ones");
        now_chk("R10 timer bit for counter 3", iti_o, 4'b1010);

        // randomized phase checked against the model every cycle
        for (int n = 0; n < 3000; n++) begin
            @(posedge clk); #2;
            reg_we  = ($urandom_range(0, 2) == 0);
            req_cpu = 2'($urandom_range(0, 3));
            tick    = ($urandom_range(0, 2) == 0);
            case ($urandom_range(0, 5))
                0: reg_addr = 12'h080;
                1: reg_addr = 12'h380;
                2: reg_addr = 12'h3C0;
                3: reg_addr = 12'h700;
                4: reg_addr = 12'h740;
                default: reg_addr = 12'h100;
            endcase
            if (reg_addr == 12'h080) reg_wdata = {32'($urandom), 32'($urandom)};
            else reg_wdata = 64'($urandom_range(0, 6));
        end
        @(posedge clk); #2 reg_we = 1'b0; tick = 1'b0;
        @(posedge clk); #2;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule